// File: doc/BRIEF.md
# Paged Register Port with Shared I2C / SPI Pins

This block lets a host processor read and write a paged bank of 8-bit configuration registers over one of two serial control protocols. A static protocol-select pin chooses between them, and the protocols share pins. When SPI is selected, the clock/select pin is the active-low chip select and the data pin is MOSI. When I2C is selected, the same two pins are SCL and SDA. A separate SPI clock pin and a MISO pin are used only by SPI. The I2C data line is modelled as a pull-down enable, so the block can only pull SDA low.

All serial inputs are synchronised into the system clock domain and sampled there. Both protocols feed one register pointer and one store. The store has `PAGES` pages of 128 byte-wide registers. Register 0 is the page selector, and it appears at address 0 of every page. After every data byte the pointer advances, so a host can read or write many consecutive registers in one burst. Other logic on the chip reads any register through a combinational tap port and sees the current page on a dedicated output.

Top module: `dual_bus_regport`

## Requirements
- R1: `proto_sel` = 1 selects SPI and `proto_sel` = 0 selects I2C. While SPI is selected, `sda_oe` stays 0. While I2C is selected, `miso` stays 0.
- R2: The I2C slave answers only the 7-bit address 0x18, where the address byte is {address, R/W} and R/W = 1 means read. On a match it pulls SDA low during the ninth clock. Any other address gets no acknowledge, and the bytes that follow it change nothing.
- R3: In an I2C write, the first byte after the address loads the register pointer from its low 7 bits. Each further byte is written at the pointer, and the pointer then advances by one.
- R4: After a repeated start with the read bit set, the I2C slave returns data MSB first, starting at the pointer and advancing by one per byte. When the master sends a not-acknowledge, the slave stops driving SDA.
- R5: SDA is only ever pulled low. `sda_oe` = 1 means pull down, and the block asserts it only for acknowledges and for read data bits that are 0.
- R6: SPI runs with clock polarity 0 and clock phase 0. The first byte of a transaction is a command: bits 7:1 are the register address and bit 0 is 1 for read. MOSI is sampled on the rising SCLK edge. MISO changes on falling edges, and the first bit of each read byte is valid before that byte's first rising edge.
- R7: SPI bursts advance the pointer by one per data byte in both directions. MISO stays 0 during the command byte and during write data bytes.
- R8: Register 0 on any page reads back as the current page. Writing it selects the page from its low bits, and later accesses in the same burst already use the new page.
- R9: The pointer wraps from 127 to 0, so a burst that runs past register 127 reaches the page selector next.
- R10: Raising the SPI chip select, or an I2C stop condition, ends the transaction. The next byte is again interpreted as a command byte (SPI) or an address byte (I2C).
- R11: After reset, every register is 0, the page is 0, `sda_oe` is 0 and `miso` is 0.
- R12: `tap_data` combinationally returns the register at (`tap_page`, `tap_addr`). When `tap_addr` is 0 it returns the current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| proto_sel | input | 1 | Static protocol select: 1 = SPI, 0 = I2C |
| scl_ssn | input | 1 | I2C SCL, or SPI chip select (active low) |
| sda_mosi | input | 1 | Sensed I2C SDA line, or SPI MOSI |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| sda_oe | output | 1 | SDA pull-down enable |
| miso | output | 1 | SPI serial data out |
| active_page | output | $clog2(PAGES) | Currently selected page |
| tap_page | input | $clog2(PAGES) | Page index for the tap read port |
| tap_addr | input | 7 | Register index for the tap read port |
| tap_data | output | 8 | Register contents at the tap location |

## Verification
- **Pointer state.** A pointer that is off by one shows on the tap port one register away from the expected one after the very next write byte. In a read burst it shows on MISO or SDA in the first data byte.
- **Page state.** A wrong page select shows at once on `active_page`. It also misplaces every later byte, so a full sweep that writes each page with a position-dependent pattern and reads all 512 locations back exposes it.
- **Protocol bookkeeping.** A stale byte counter after a chip-select rise or a stop shows in the next transaction: its first byte lands as data instead of steering the pointer.
- **Acknowledge timing.** A misplaced acknowledge or a stuck pull-down shows within one SCL period as a wrong acknowledge bit or as corrupted read data.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int REG_AW = 7;
  localparam int REGS   = 1 << REG_AW;
  localparam int DW     = 8;

  typedef enum logic [2:0] {
    I2C_IDLE,
    I2C_RX,
    I2C_ACK,
    I2C_TX,
    I2C_MACK,
    I2C_NEXT
  } i2c_st_t;
endpackage

// File: rtl/regport_edge_sync.sv
module regport_edge_sync #(
  parameter int           N    = 3,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= IDLE[i];
        s2_q[i] <= IDLE[i];
        s3_q[i] <= IDLE[i];
      end else begin
        s1_q[i] <= pin[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end
    assign lvl[i]  = s2_q[i];
    assign rise[i] = s2_q[i] & ~s3_q[i];
    assign fall[i] = ~s2_q[i] & s3_q[i];
  end
endmodule

// File: rtl/regport_store.sv
module regport_store
  import regport_pkg::*;
#(
  parameter int  PAGES = 4,
  localparam int PGW   = $clog2(PAGES),
  localparam int DEPTH = PAGES * REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ptr,
  input  logic [REG_AW-1:0] set_val,
  input  logic              wr,
  input  logic [DW-1:0]     wr_data,
  input  logic              adv,
  output logic [DW-1:0]     rd_data,
  output logic [PGW-1:0]    page,
  input  logic [PGW-1:0]    tap_page,
  input  logic [REG_AW-1:0] tap_addr,
  output logic [DW-1:0]     tap_data
);
  logic [DW-1:0]         mem_q [DEPTH];
  logic [REG_AW-1:0]     ptr_q, ptr_d;
  logic [PGW-1:0]        page_q, page_d;
  logic                  mem_we;
  logic [PGW+REG_AW-1:0] widx, tidx;

  assign widx = {page_q, ptr_q};
  assign tidx = {tap_page, tap_addr};

  always_comb begin
    ptr_d  = ptr_q;
    page_d = page_q;
    mem_we = 1'b0;
    if (set_ptr) ptr_d = set_val;
    else if (wr || adv) ptr_d = ptr_q + 1'b1;
    if (wr && ptr_q == '0) page_d = wr_data[PGW-1:0];
    else if (wr) mem_we = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (mem_we) begin
      mem_q[widx] <= wr_data;
    end
  end

  assign rd_data  = (ptr_q == '0) ? {{(DW-PGW){1'b0}}, page_q} : mem_q[widx];
  assign tap_data = (tap_addr == '0) ? {{(DW-PGW){1'b0}}, page_q} : mem_q[tidx];
  assign page     = page_q;

  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || adv) && !set_ptr && ptr_q == '1) |=> ptr_q == '0);

  p_page_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !set_ptr && ptr_q == '0) |=> page_q == $past(wr_data[PGW-1:0]));
endmodule

// File: rtl/regport_spi_fsm.sv
module regport_spi_fsm
  import regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ssn_lvl,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_lvl,
  input  logic [DW-1:0]     rd_data,
  output logic              set_ptr,
  output logic [REG_AW-1:0] set_val,
  output logic              wr,
  output logic [DW-1:0]     wr_data,
  output logic              adv,
  output logic              miso
);
  logic          active;
  logic [2:0]    bitcnt_q, bitcnt_d;
  logic          first_q, first_d;
  logic          rdmode_q, rdmode_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] byte_in;

  assign active  = en && !ssn_lvl;
  assign byte_in = {rx_q[DW-2:0], mosi_lvl};

  always_comb begin
    bitcnt_d = bitcnt_q;
    first_d  = first_q;
    rdmode_d = rdmode_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    set_ptr  = 1'b0;
    set_val  = byte_in[DW-1:1];
    wr       = 1'b0;
    wr_data  = byte_in;
    adv      = 1'b0;
    if (!active) begin
      bitcnt_d = '0;
      first_d  = 1'b1;
      rdmode_d = 1'b0;
      tx_d     = '0;
    end else if (sclk_rise) begin
      rx_d     = byte_in;
      bitcnt_d = bitcnt_q + 3'd1;
      if (bitcnt_q == 3'd7) begin
        if (first_q) begin
          set_ptr  = 1'b1;
          rdmode_d = byte_in[0];
          first_d  = 1'b0;
        end else if (!rdmode_q) begin
          wr = 1'b1;
        end
      end
    end else if (sclk_fall) begin
      if (bitcnt_q != 3'd0) begin
        tx_d = {tx_q[DW-2:0], 1'b0};
      end else if (!first_q && rdmode_q) begin
        tx_d = rd_data;
        adv  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt_q <= '0;
      first_q  <= 1'b1;
      rdmode_q <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '0;
    end else begin
      bitcnt_q <= bitcnt_d;
      first_q  <= first_d;
      rdmode_q <= rdmode_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
    end
  end

  assign miso = tx_q[DW-1];

  p_cs_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ssn_lvl |=> (bitcnt_q == 3'd0 && first_q && tx_q == '0));

  p_write_miso_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdmode_q |-> tx_q == '0);
endmodule

// File: rtl/regport_i2c_fsm.sv
module regport_i2c_fsm
  import regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [DW-1:0]     rd_data,
  output logic              set_ptr,
  output logic [REG_AW-1:0] set_val,
  output logic              wr,
  output logic [DW-1:0]     wr_data,
  output logic              adv,
  output logic              sda_oe
);
  i2c_st_t       st_q, st_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          is_addr_q, is_addr_d;
  logic          rw_q, rw_d;
  logic          have_ptr_q, have_ptr_d;
  logic          oe_q, oe_d;
  logic          start_c, stop_c;
  logic [DW-1:0] byte_in;

  assign start_c = en && scl_lvl && sda_fall;
  assign stop_c  = en && scl_lvl && sda_rise;
  assign byte_in = {rx_q[DW-2:0], sda_lvl};

  always_comb begin
    st_d       = st_q;
    bitcnt_d   = bitcnt_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    is_addr_d  = is_addr_q;
    rw_d       = rw_q;
    have_ptr_d = have_ptr_q;
    oe_d       = oe_q;
    set_ptr    = 1'b0;
    set_val    = byte_in[REG_AW-1:0];
    wr         = 1'b0;
    wr_data    = byte_in;
    adv        = 1'b0;
    if (!en) begin
      st_d     = I2C_IDLE;
      oe_d     = 1'b0;
      bitcnt_d = '0;
    end else if (stop_c) begin
      st_d = I2C_IDLE;
      oe_d = 1'b0;
    end else if (start_c) begin
      st_d       = I2C_RX;
      is_addr_d  = 1'b1;
      have_ptr_d = 1'b0;
      bitcnt_d   = '0;
      oe_d       = 1'b0;
    end else begin
      unique case (st_q)
        I2C_RX: if (scl_rise) begin
          rx_d     = byte_in;
          bitcnt_d = bitcnt_q + 4'd1;
          if (bitcnt_q == 4'd7) begin
            if (is_addr_q) begin
              if (byte_in[7:1] == DEV_ADDR) begin
                rw_d = byte_in[0];
                st_d = I2C_ACK;
              end else begin
                st_d = I2C_IDLE;
              end
            end else begin
              if (!have_ptr_q) begin
                set_ptr    = 1'b1;
                have_ptr_d = 1'b1;
              end else begin
                wr = 1'b1;
              end
              st_d = I2C_ACK;
            end
          end
        end
        I2C_ACK: if (scl_fall) begin
          if (!oe_q) begin
            oe_d = 1'b1;
          end else begin
            oe_d      = 1'b0;
            bitcnt_d  = '0;
            is_addr_d = 1'b0;
            if (is_addr_q && rw_q) begin
              tx_d = rd_data;
              adv  = 1'b1;
              oe_d = !rd_data[DW-1];
              st_d = I2C_TX;
            end else begin
              st_d = I2C_RX;
            end
          end
        end
        I2C_TX: begin
          if (scl_rise) bitcnt_d = bitcnt_q + 4'd1;
          if (scl_fall) begin
            if (bitcnt_q != 4'd8) begin
              tx_d = {tx_q[DW-2:0], 1'b0};
              oe_d = !tx_q[DW-2];
            end else begin
              oe_d = 1'b0;
              st_d = I2C_MACK;
            end
          end
        end
        I2C_MACK: if (scl_rise) st_d = sda_lvl ? I2C_IDLE : I2C_NEXT;
        I2C_NEXT: if (scl_fall) begin
          tx_d     = rd_data;
          adv      = 1'b1;
          oe_d     = !rd_data[DW-1];
          bitcnt_d = '0;
          st_d     = I2C_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= I2C_IDLE;
      bitcnt_q   <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      is_addr_q  <= 1'b0;
      rw_q       <= 1'b0;
      have_ptr_q <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      bitcnt_q   <= bitcnt_d;
      rx_q       <= rx_d;
      tx_q       <= tx_d;
      is_addr_q  <= is_addr_d;
      rw_q       <= rw_d;
      have_ptr_q <= have_ptr_d;
      oe_q       <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st_q == I2C_IDLE && !oe_q));

  p_foreign_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start_c && !stop_c && st_q == I2C_RX && is_addr_q && scl_rise &&
     bitcnt_q == 4'd7 && byte_in[7:1] != DEV_ADDR) |=> st_q == I2C_IDLE);

  p_pull_only_when_owed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (st_q == I2C_ACK || st_q == I2C_TX));

  p_quiet_when_spi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !oe_q);
endmodule

// File: rtl/dual_bus_regport.sv
module dual_bus_regport
  import regport_pkg::*;
#(
  parameter int         PAGES    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h18,
  localparam int        PGW      = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proto_sel,
  input  logic              scl_ssn,
  input  logic              sda_mosi,
  input  logic              spi_sclk,
  output logic              sda_oe,
  output logic              miso,
  output logic [PGW-1:0]    active_page,
  input  logic [PGW-1:0]    tap_page,
  input  logic [REG_AW-1:0] tap_addr,
  output logic [DW-1:0]     tap_data
);
  localparam int PIN_CS   = 0;
  localparam int PIN_DATA = 1;
  localparam int PIN_SCLK = 2;

  logic [2:0] p_lvl, p_rise, p_fall;

  regport_edge_sync #(.N(3), .IDLE(3'b011)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .pin ({spi_sclk, sda_mosi, scl_ssn}),
    .lvl (p_lvl), .rise (p_rise), .fall (p_fall)
  );

  logic [DW-1:0]     rd_data;
  logic              s_set, i_set, set_ptr;
  logic [REG_AW-1:0] s_val, i_val, set_val;
  logic              s_wr, i_wr, wr;
  logic [DW-1:0]     s_wd, i_wd, wr_data;
  logic              s_adv, i_adv, adv;
  logic              spi_miso, i2c_oe;

  regport_spi_fsm u_spi (
    .clk (clk), .rst_n (rst_n), .en (proto_sel),
    .ssn_lvl (p_lvl[PIN_CS]), .sclk_rise (p_rise[PIN_SCLK]), .sclk_fall (p_fall[PIN_SCLK]),
    .mosi_lvl (p_lvl[PIN_DATA]), .rd_data (rd_data),
    .set_ptr (s_set), .set_val (s_val), .wr (s_wr), .wr_data (s_wd), .adv (s_adv),
    .miso (spi_miso)
  );

  regport_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_i2c (
    .clk (clk), .rst_n (rst_n), .en (!proto_sel),
    .scl_lvl (p_lvl[PIN_CS]), .scl_rise (p_rise[PIN_CS]), .scl_fall (p_fall[PIN_CS]),
    .sda_lvl (p_lvl[PIN_DATA]), .sda_rise (p_rise[PIN_DATA]), .sda_fall (p_fall[PIN_DATA]),
    .rd_data (rd_data),
    .set_ptr (i_set), .set_val (i_val), .wr (i_wr), .wr_data (i_wd), .adv (i_adv),
    .sda_oe (i2c_oe)
  );

  always_comb begin
    if (proto_sel) begin
      set_ptr = s_set; set_val = s_val; wr = s_wr; wr_data = s_wd; adv = s_adv;
    end else begin
      set_ptr = i_set; set_val = i_val; wr = i_wr; wr_data = i_wd; adv = i_adv;
    end
  end

  regport_store #(.PAGES(PAGES)) u_store (
    .clk (clk), .rst_n (rst_n),
    .set_ptr (set_ptr), .set_val (set_val), .wr (wr), .wr_data (wr_data), .adv (adv),
    .rd_data (rd_data), .page (active_page),
    .tap_page (tap_page), .tap_addr (tap_addr), .tap_data (tap_data)
  );

  assign sda_oe = i2c_oe;
  assign miso   = spi_miso;

  p_single_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_ptr, wr, adv}));
endmodule

// File: tb/dual_bus_regport_tb.sv
module dual_bus_regport_tb;
  localparam int CLK_P = 10;
  localparam int H     = 6;
  localparam int NPG   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proto_sel = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic ssn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [1:0] tap_page = '0;
  logic [6:0] tap_addr = '0;
  logic sda_oe, miso;
  logic [1:0] active_page;
  logic [7:0] tap_data;
  logic sda_line;

  always #(CLK_P/2) clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  dual_bus_regport #(.PAGES(NPG)) u_dut (
    .clk (clk), .rst_n (rst_n), .proto_sel (proto_sel),
    .scl_ssn (proto_sel ? ssn : m_scl),
    .sda_mosi (proto_sel ? mosi : sda_line),
    .spi_sclk (sclk), .sda_oe (sda_oe), .miso (miso),
    .active_page (active_page), .tap_page (tap_page), .tap_addr (tap_addr),
    .tap_data (tap_data)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int bad_oe = 0, bad_miso = 0;
  logic [7:0] exp_mem [NPG*128];
  int exp_page = 0;

  always @(negedge clk) if (rst_n) begin
    if (proto_sel && sda_oe) bad_oe++;
    if (!proto_sel && miso) bad_miso++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int pg, input int r);
    return 8'((pg * 37 + r * 5 + 1) & 255);
  endfunction

  task automatic tap_check(input string req, input int pg, input int r);
    tap_page = 2'(pg); tap_addr = 7'(r);
    hw(1);
    check(req, int'(tap_data), (r == 0) ? exp_page : int'(exp_mem[pg*128+r]));
  endtask

  // model of a write at (current page, pointer) with pointer advance
  task automatic model_wr(inout int ptr, input logic [7:0] b);
    if (ptr == 0) exp_page = int'(b) % NPG;
    else exp_mem[exp_page*128+ptr] = b;
    ptr = (ptr + 1) % 128;
  endtask

  function automatic logic [7:0] model_rd(input int ptr);
    return (ptr == 0) ? 8'(exp_page) : exp_mem[exp_page*128+ptr];
  endfunction

  // ---------------- SPI master ----------------
  task automatic spi_begin();
    ssn = 1'b0; hw(H);
  endtask
  task automatic spi_end();
    hw(H); ssn = 1'b1; hw(H);
  endtask
  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i]; hw(H);
      rx[i] = miso; sclk = 1'b1; hw(H);
      sclk = 1'b0;
    end
  endtask

  // ---------------- I2C master ----------------
  task automatic i2c_start();
    m_sda = 1'b0; hw(H); m_scl = 1'b0; hw(2);
  endtask
  task automatic i2c_rstart();
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b0; hw(H); m_scl = 1'b0; hw(2);
  endtask
  task automatic i2c_stop();
    m_sda = 1'b0; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b1; hw(H);
  endtask
  task automatic i2c_wbyte(input logic [7:0] b, output bit ack, output bit pulled);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0; hw(2);
    end
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H);
    ack = !sda_line; pulled = sda_oe;
    m_scl = 1'b0; hw(2);
  endtask
  task automatic i2c_rbyte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H); b[i] = sda_line; m_scl = 1'b0; hw(2);
    end
    m_sda = !ack; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0; hw(2); m_sda = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    bit ack, pulled;
    int ptr, errs;
    for (int i = 0; i < NPG*128; i++) exp_mem[i] = '0;
    hw(4); rst_n = 1'b1; hw(4);

    // R11: reset state
    check("R11 sda_oe", int'(sda_oe), 0);
    check("R11 miso", int'(miso), 0);
    check("R11 page", int'(active_page), 0);
    tap_check("R11 reg", 0, 5);
    tap_check("R11 reg", 3, 127);

    // R6 R7 R8: SPI write sweep, page chosen inside the burst
    proto_sel = 1'b1; hw(8);
    for (int pg = 0; pg < NPG; pg++) begin
      errs = 0; ptr = 0;
      spi_begin();
      spi_byte(8'h00, rb); errs += (rb != 0);
      spi_byte(8'(pg), rb); errs += (rb != 0); model_wr(ptr, 8'(pg));
      for (int r = 1; r < 128; r++) begin
        spi_byte(pat(pg, r), rb); errs += (rb != 0); model_wr(ptr, pat(pg, r));
      end
      spi_end();
      check("R7 miso low on write", errs, 0);
      check("R8 page after burst", int'(active_page), pg);
    end
    // R12: exhaustive tap sweep
    for (int pg = 0; pg < NPG; pg++)
      for (int r = 0; r < 128; r++) tap_check("R12 tap", pg, r);

    // R6 R7: SPI read burst of page 3
    spi_begin();
    spi_byte({7'd1, 1'b1}, rb);
    check("R7 miso low in command", int'(rb), 0);
    for (int r = 1; r < 128; r++) begin
      spi_byte(8'h00, rb); check("R6 spi read", int'(rb), int'(model_rd(r)));
    end
    spi_end();

    // R8 R9: switch to page 1, read across the wrap
    spi_begin(); spi_byte(8'h00, rb); spi_byte(8'h01, rb); spi_end(); exp_page = 1;
    check("R8 page select", int'(active_page), 1);
    spi_begin();
    spi_byte({7'd126, 1'b1}, rb);
    spi_byte(8'h00, rb); check("R9 read 126", int'(rb), int'(pat(1, 126)));
    spi_byte(8'h00, rb); check("R9 read 127", int'(rb), int'(pat(1, 127)));
    spi_byte(8'h00, rb); check("R9 wrap reads page", int'(rb), 1);
    spi_end();

    // R10: chip select rise restarts the command phase
    spi_begin(); spi_byte({7'd20, 1'b0}, rb); spi_byte(8'h11, rb); spi_end();
    exp_mem[128+20] = 8'h11;
    spi_begin(); spi_byte({7'd21, 1'b0}, rb); spi_byte(8'h22, rb); spi_end();
    exp_mem[128+21] = 8'h22;
    tap_check("R10 spi reg20", 1, 20);
    tap_check("R10 spi reg21", 1, 21);
    tap_check("R10 spi reg22", 1, 22);
    tap_check("R10 spi reg42 untouched", 1, 42);
    check("R1 no sda pull in spi mode", bad_oe, 0);

    // ---------------- I2C ----------------
    proto_sel = 1'b0; hw(8);
    // R2: foreign address is ignored
    i2c_start();
    i2c_wbyte(8'h32, ack, pulled); check("R2 foreign nack", int'(ack), 0);
    i2c_wbyte(8'h05, ack, pulled); i2c_wbyte(8'h77, ack, pulled);
    i2c_stop();
    tap_check("R2 foreign no write", 1, 5);
    tap_check("R2 foreign no write", 1, 6);

    // R3 R5: write burst
    i2c_start();
    i2c_wbyte(8'h30, ack, pulled);
    check("R2 own address ack", int'(ack), 1);
    check("R5 pull-down on ack", int'(pulled), 1);
    i2c_wbyte(8'h05, ack, pulled); check("R3 pointer ack", int'(ack), 1);
    i2c_wbyte(8'hC1, ack, pulled); i2c_wbyte(8'hC2, ack, pulled); i2c_wbyte(8'hC3, ack, pulled);
    check("R3 data ack", int'(ack), 1);
    i2c_stop();
    check("R5 released after stop", int'(sda_oe), 0);
    exp_mem[128+5] = 8'hC1; exp_mem[128+6] = 8'hC2; exp_mem[128+7] = 8'hC3;
    for (int r = 4; r <= 8; r++) tap_check("R3 i2c write", 1, r);

    // R4: pointer write, repeated start, read burst with final nack
    i2c_start(); i2c_wbyte(8'h30, ack, pulled); i2c_wbyte(8'h04, ack, pulled);
    i2c_rstart(); i2c_wbyte(8'h31, ack, pulled); check("R4 read address ack", int'(ack), 1);
    for (int r = 4; r <= 8; r++) begin
      i2c_rbyte(r != 8, rb); check("R4 i2c read", int'(rb), int'(model_rd(r)));
    end
    hw(2); check("R4 released after nack", int'(sda_oe), 0);
    i2c_stop();

    // R8: page select over I2C, later bytes go to the new page
    i2c_start(); i2c_wbyte(8'h30, ack, pulled); i2c_wbyte(8'h00, ack, pulled);
    i2c_wbyte(8'h02, ack, pulled); i2c_wbyte(8'h5A, ack, pulled); i2c_stop();
    exp_page = 2; exp_mem[256+1] = 8'h5A;
    check("R8 i2c page", int'(active_page), 2);
    tap_check("R8 new page written", 2, 1);
    tap_check("R8 old page kept", 1, 1);

    // R10: stop restarts the address phase
    i2c_start(); i2c_wbyte(8'h30, ack, pulled); i2c_wbyte(8'h10, ack, pulled);
    i2c_wbyte(8'h99, ack, pulled); i2c_stop();
    i2c_start(); i2c_wbyte(8'h30, ack, pulled); i2c_wbyte(8'h12, ack, pulled);
    i2c_wbyte(8'h44, ack, pulled); i2c_stop();
    exp_mem[256+16] = 8'h99; exp_mem[256+18] = 8'h44;
    tap_check("R10 i2c reg10", 2, 16);
    tap_check("R10 i2c reg11 untouched", 2, 17);
    tap_check("R10 i2c reg12", 2, 18);

    // R9: write wraps from 127 into the page selector
    i2c_start(); i2c_wbyte(8'h30, ack, pulled); i2c_wbyte(8'h7F, ack, pulled);
    i2c_wbyte(8'hE7, ack, pulled); i2c_wbyte(8'h03, ack, pulled); i2c_stop();
    exp_mem[256+127] = 8'hE7; exp_page = 3;
    tap_check("R9 reg127", 2, 127);
    check("R9 wrap to page select", int'(active_page), 3);

    // R4: full-page I2C read of page 3
    i2c_start(); i2c_wbyte(8'h30, ack, pulled); i2c_wbyte(8'h01, ack, pulled);
    i2c_rstart(); i2c_wbyte(8'h31, ack, pulled);
    errs = 0;
    for (int r = 1; r < 128; r++) begin
      i2c_rbyte(r != 127, rb);
      if (rb != model_rd(r)) begin
        errs++;
        $display("FAIL R4 page read reg %0d: actual %0h expected %0h", r, rb, model_rd(r));
      end
    end
    i2c_stop();
    check("R4 page read mismatches", errs, 0);
    check("R1 miso quiet in i2c mode", bad_miso, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule